// File: doc/BRIEF.md
# Debug Messaging Control and Status Register

This block is a 32-bit monitor and control register for a processor debug unit. Two parties can access it. The core reaches it over a bus port, and an external debugger reaches it over a host port. Both ports read the same value. The upper half holds control bits that software can read and write. The lower half holds sticky status bits, which event logic elsewhere in the debug unit sets.

The block also tracks two message-buffer flags. The receive flag means the host has left a word for the core. The transmit flag means the core has left a word for the host. From these flags and their enable bits, the block raises a debug exception request, so that message passing can be driven by interrupts. A trace-buffer-full flag records that the core entered debug mode because its trace buffer filled. Four ownership flags let competing debuggers reserve the core.

Two resets apply. Power-on reset clears everything. Core reset clears everything except the ownership flags.

Top module: `dbg_msg_csr`

## Requirements
- R1: Both ports read the same 32-bit value, laid out as follows. Bit 24 is the transmit exception enable. Bit 23 is the trace-full flag. Bit 22 is the receive exception enable. Bits 21:18 are the ownership flags. Bits 15:0 are the sticky status bits. Bits 31:25 and 17:16 read as zero.
- R2: A high on event input n sets status bit n at the next clock edge. The bit stays set until a register write carries 0 in bit n. A write carrying 1 in bit n leaves the bit unchanged.
- R3: When an event for status bit n and a write clearing bit n arrive in the same cycle, the bit is set afterwards.
- R4: Writes to bits 31:25, 17:16 and 23 have no effect on the value read back.
- R5: When both ports write in the same cycle, only the host-port data takes effect.
- R6: A host receive-data write strobe sets the receive-full flag, and a core receive-data read strobe clears it. A core transmit-data write strobe sets the transmit-full flag, and a host transmit-data read strobe clears it. For each flag, a set and a clear in the same cycle leave the flag set.
- R7: The exception request is high in every cycle in which the receive enable and the receive-full flag are both set.
- R8: The exception request pulses high for exactly one cycle. That cycle is the first one in which the transmit-full flag reads 0 after reading 1, and the pulse occurs only if the transmit enable was set when the clear was taken.
- R9: A pulse on the trace-full input sets bit 23 at the next edge. The bit then holds until a reset.
- R10: An active core reset clears all bits except bits 21:18, and it also clears both message flags and the exception request. Bits 21:18 hold their value through a core reset, and writes to them are ignored while it is active.
- R11: Power-on reset clears every bit, both message flags and the exception request. It takes priority over all other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| core_rst_n | input | 1 | Core reset, active low, synchronous |
| core_we | input | 1 | Core-port register write strobe |
| core_wdata | input | 32 | Core-port write data |
| core_rdata | output | 32 | Core-port read data |
| host_we | input | 1 | Host-port register write strobe |
| host_wdata | input | 32 | Host-port write data |
| host_rdata | output | 32 | Host-port read data |
| evt_in | input | 16 | Event inputs that set the sticky status bits |
| trc_full_in | input | 1 | Pulse: debug entry caused by a full trace buffer |
| host_rx_wr | input | 1 | Host wrote the receive data register |
| core_rx_rd | input | 1 | Core read the receive data register |
| core_tx_wr | input | 1 | Core wrote the transmit data register |
| host_tx_rd | input | 1 | Host read the transmit data register |
| rx_full | output | 1 | Receive-full flag |
| tx_full | output | 1 | Transmit-full flag |
| dbg_exc_req | output | 1 | Debug exception request |

## Verification
Read data is built directly from register state. A wrong status, control or trace bit therefore shows on both read ports in the first cycle after the edge that stored it, with no further delay. A corrupted message flag appears on its own output at once. A missed or doubled transmit pulse appears on the exception output in the one cycle where the flag first reads 0, or in the cycle after it. The directed tests sample exactly those cycles. They also check the ownership bits across a core reset, because a wrong reset domain would otherwise stay hidden until the next power-on reset.

// File: rtl/dbg_msg_pkg.sv
package dbg_msg_pkg;
    localparam int REG_W    = 32;
    localparam int STAT_W   = 16;
    localparam int OWN_W    = 4;
    localparam int TXEN_BIT = 24;
    localparam int TRC_BIT  = 23;
    localparam int RXEN_BIT = 22;
    localparam int OWN_LSB  = 18;

    typedef struct packed {
        logic             tx_en;
        logic             rx_en;
        logic [OWN_W-1:0] own;
        logic             trc;
    } ctrl_t;

    typedef struct packed {
        logic rx_full;
        logic tx_full;
        logic tx_pulse;
    } flag_t;
endpackage

// File: rtl/dbg_msg_ctrl.sv
module dbg_msg_ctrl
    import dbg_msg_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             core_rst_n,
    input  logic             wr_en,
    input  logic             wr_tx_en,
    input  logic             wr_rx_en,
    input  logic [OWN_W-1:0] wr_own,
    input  logic             trc_set,
    output ctrl_t            ctrl_o
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (core_rst_n) begin
            if (wr_en) begin
                ctrl_d.tx_en = wr_tx_en;
                ctrl_d.rx_en = wr_rx_en;
                ctrl_d.own   = wr_own;
            end
            if (trc_set) begin
                ctrl_d.trc = 1'b1;
            end
        end else begin
            // core reset: ownership flags keep their value
            ctrl_d.tx_en = 1'b0;
            ctrl_d.rx_en = 1'b0;
            ctrl_d.trc   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;

    AST_OWN_HELD: assert property (@(posedge clk) disable iff (!por_n)
        !core_rst_n |=> (ctrl_q.own == $past(ctrl_q.own))); // R10
    AST_TRC_SET: assert property (@(posedge clk) disable iff (!por_n || !core_rst_n)
        trc_set |=> ctrl_q.trc); // R9
    AST_TRC_HOLD: assert property (@(posedge clk) disable iff (!por_n || !core_rst_n)
        ctrl_q.trc |=> ctrl_q.trc); // R9
endmodule

// File: rtl/dbg_msg_sticky.sv
module dbg_msg_sticky
    import dbg_msg_pkg::*;
#(
    parameter int W = STAT_W
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         core_rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_bits,
    input  logic [W-1:0] evt,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (wr_en) begin
            stat_d = stat_q & wr_bits;   // a 0 clears, a 1 keeps
        end
        stat_d = stat_d | evt;           // event beats a clear
        if (!core_rst_n) begin
            stat_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_o = stat_q;

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!por_n || !core_rst_n)
        1'b1 |=> ((stat_q & $past(evt)) == $past(evt))); // R3
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!por_n || !core_rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt)) == '0)); // R2
endmodule

// File: rtl/dbg_msg_flags.sv
module dbg_msg_flags
    import dbg_msg_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic core_rst_n,
    input  logic rx_set,
    input  logic rx_clr,
    input  logic tx_set,
    input  logic tx_clr,
    input  logic rx_en,
    input  logic tx_en,
    output logic rx_full,
    output logic tx_full,
    output logic exc_req
);
    flag_t flag_d, flag_q;

    always_comb begin
        flag_d          = flag_q;
        flag_d.rx_full  = rx_set | (flag_q.rx_full & ~rx_clr);
        flag_d.tx_full  = tx_set | (flag_q.tx_full & ~tx_clr);
        flag_d.tx_pulse = tx_en & flag_q.tx_full & ~flag_d.tx_full;
        if (!core_rst_n) begin
            flag_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign rx_full = flag_q.rx_full;
    assign tx_full = flag_q.tx_full;
    assign exc_req = (rx_en & flag_q.rx_full) | flag_q.tx_pulse;

    AST_TX_ONE_SHOT: assert property (@(posedge clk) disable iff (!por_n || !core_rst_n)
        flag_q.tx_pulse |=> !flag_q.tx_pulse); // R8
    AST_TX_AFTER_FALL: assert property (@(posedge clk) disable iff (!por_n || !core_rst_n)
        flag_q.tx_pulse |-> (!flag_q.tx_full && $past(flag_q.tx_full))); // R8
    AST_RX_SET_WINS: assert property (@(posedge clk) disable iff (!por_n || !core_rst_n)
        rx_set |=> flag_q.rx_full); // R6
endmodule

// File: rtl/dbg_msg_csr.sv
module dbg_msg_csr
    import dbg_msg_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              core_rst_n,
    input  logic              core_we,
    input  logic [REG_W-1:0]  core_wdata,
    output logic [REG_W-1:0]  core_rdata,
    input  logic              host_we,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata,
    input  logic [STAT_W-1:0] evt_in,
    input  logic              trc_full_in,
    input  logic              host_rx_wr,
    input  logic              core_rx_rd,
    input  logic              core_tx_wr,
    input  logic              host_tx_rd,
    output logic              rx_full,
    output logic              tx_full,
    output logic              dbg_exc_req
);
    logic              wr_en;
    logic [REG_W-1:0]  wr_data;
    logic              rsvd_unused;
    ctrl_t             ctrl;
    logic [STAT_W-1:0] stat;
    logic [REG_W-1:0]  rd_word;

    // host port wins a same-cycle collision
    assign wr_en   = host_we | core_we;
    assign wr_data = host_we ? host_wdata : core_wdata;
    assign rsvd_unused = ^{wr_data[REG_W-1:TXEN_BIT+1], wr_data[TRC_BIT],
                           wr_data[OWN_LSB-1:STAT_W]};

    dbg_msg_ctrl u_ctrl (
        .clk        (clk),
        .por_n      (por_n),
        .core_rst_n (core_rst_n),
        .wr_en      (wr_en),
        .wr_tx_en   (wr_data[TXEN_BIT]),
        .wr_rx_en   (wr_data[RXEN_BIT]),
        .wr_own     (wr_data[OWN_LSB +: OWN_W]),
        .trc_set    (trc_full_in),
        .ctrl_o     (ctrl)
    );

    dbg_msg_sticky #(.W(STAT_W)) u_sticky (
        .clk        (clk),
        .por_n      (por_n),
        .core_rst_n (core_rst_n),
        .wr_en      (wr_en),
        .wr_bits    (wr_data[STAT_W-1:0]),
        .evt        (evt_in),
        .stat_o     (stat)
    );

    dbg_msg_flags u_flags (
        .clk        (clk),
        .por_n      (por_n),
        .core_rst_n (core_rst_n),
        .rx_set     (host_rx_wr),
        .rx_clr     (core_rx_rd),
        .tx_set     (core_tx_wr),
        .tx_clr     (host_tx_rd),
        .rx_en      (ctrl.rx_en),
        .tx_en      (ctrl.tx_en),
        .rx_full    (rx_full),
        .tx_full    (tx_full),
        .exc_req    (dbg_exc_req)
    );

    always_comb begin
        rd_word                       = '0;
        rd_word[TXEN_BIT]             = ctrl.tx_en;
        rd_word[TRC_BIT]              = ctrl.trc;
        rd_word[RXEN_BIT]             = ctrl.rx_en;
        rd_word[OWN_LSB +: OWN_W]     = ctrl.own;
        rd_word[STAT_W-1:0]           = stat;
    end

    assign core_rdata = rd_word;
    assign host_rdata = rd_word;

    AST_HOST_WINS: assert property (@(posedge clk) disable iff (!por_n || !core_rst_n)
        (host_we && core_we) |=>
        (host_rdata[OWN_LSB +: OWN_W] == $past(host_wdata[OWN_LSB +: OWN_W]))); // R5
    AST_RX_EXC_LEVEL: assert property (@(posedge clk) disable iff (!por_n || !core_rst_n)
        (rx_full && host_rdata[RXEN_BIT]) |-> dbg_exc_req); // R7
endmodule

// File: tb/dbg_msg_csr_tb_top.sv
module dbg_msg_csr_tb_top;
    logic        clk = 1'b0;
    logic        por_n = 1'b0, core_rst_n = 1'b1;
    logic        core_we = 1'b0, host_we = 1'b0;
    logic [31:0] core_wdata = '0, host_wdata = '0;
    logic [31:0] core_rdata, host_rdata;
    logic [15:0] evt_in = '0;
    logic        trc_full_in = 1'b0;
    logic        host_rx_wr = 1'b0, core_rx_rd = 1'b0, core_tx_wr = 1'b0, host_tx_rd = 1'b0;
    logic        rx_full, tx_full, dbg_exc_req;
    int          checks = 0, failures = 0;

    always #4 clk = ~clk;   // 125 MHz

    dbg_msg_csr dut_i (
        .clk(clk), .por_n(por_n), .core_rst_n(core_rst_n),
        .core_we(core_we), .core_wdata(core_wdata), .core_rdata(core_rdata),
        .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .evt_in(evt_in), .trc_full_in(trc_full_in),
        .host_rx_wr(host_rx_wr), .core_rx_rd(core_rx_rd),
        .core_tx_wr(core_tx_wr), .host_tx_rd(host_tx_rd),
        .rx_full(rx_full), .tx_full(tx_full), .dbg_exc_req(dbg_exc_req)
    );

    typedef struct packed {
        logic        hwe;
        logic [31:0] hwd;
        logic        cwe;
        logic [31:0] cwd;
        logic [15:0] evt;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 32'h0000_0000, 1'b0, 32'h0000_0000, 16'h0005, 32'h0000_0005},  // R2 events set
        '{1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 16'h0000, 32'h017C_0005},  // R4 R2 ones keep
        '{1'b0, 32'h0000_0000, 1'b1, 32'h0000_FFFE, 16'h0000, 32'h0000_0004},  // R2 zero clears
        '{1'b1, 32'h0004_0000, 1'b1, 32'h0100_0000, 16'h0000, 32'h0004_0000},  // R5 host wins
        '{1'b1, 32'h0004_0000, 1'b0, 32'h0000_0000, 16'h8001, 32'h0004_8001},  // R3 event wins
        '{1'b0, 32'h0000_0000, 1'b1, 32'h0004_7FFF, 16'h0000, 32'h0004_0001},  // R2 single clear
        '{1'b0, 32'h0000_0000, 1'b0, 32'h0000_0000, 16'h0100, 32'h0004_0101}   // R2 accumulate
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        core_we = 0; host_we = 0; core_wdata = '0; host_wdata = '0; evt_in = '0;
        trc_full_in = 0; host_rx_wr = 0; core_rx_rd = 0; core_tx_wr = 0; host_tx_rd = 0;
        core_rst_n = 1; por_n = 1;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic hwrite(input logic [31:0] d);
        host_we = 1; host_wdata = d;
        step();
    endtask

    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        chk("R11 reset host_rdata", host_rdata, 32'h0);
        chk("R11 reset flags/exc", {29'h0, rx_full, tx_full, dbg_exc_req}, 32'h0);
        idle();

        for (int i = 0; i < 7; i++) begin
            host_we = VECS[i].hwe; host_wdata = VECS[i].hwd;
            core_we = VECS[i].cwe; core_wdata = VECS[i].cwd;
            evt_in  = VECS[i].evt;
            step();
            chk("R1 R2 R3 R4 R5 vector host", host_rdata, VECS[i].exp);
            chk("R1 vector core", core_rdata, VECS[i].exp);
        end

        // receive path
        hwrite(32'h0040_0000);
        chk("R1 rx enable", host_rdata, 32'h0040_0000);
        host_rx_wr = 1; step();
        chk("R6 rx set", {31'h0, rx_full}, 32'h1);
        chk("R7 rx exc", {31'h0, dbg_exc_req}, 32'h1);
        step();
        chk("R7 rx exc level", {31'h0, dbg_exc_req}, 32'h1);
        core_rx_rd = 1; step();
        chk("R6 rx clear", {30'h0, rx_full, dbg_exc_req}, 32'h0);
        host_rx_wr = 1; core_rx_rd = 1; step();
        chk("R6 rx set wins", {30'h0, rx_full, dbg_exc_req}, 32'h3);
        hwrite(32'h0);
        chk("R7 rx disabled", {30'h0, rx_full, dbg_exc_req}, 32'h2);
        core_rx_rd = 1; step();

        // transmit path
        hwrite(32'h0100_0000);
        core_tx_wr = 1; step();
        chk("R6 tx set", {30'h0, tx_full, dbg_exc_req}, 32'h2);
        host_tx_rd = 1; step();
        chk("R8 tx pulse", {30'h0, tx_full, dbg_exc_req}, 32'h1);
        step();
        chk("R8 tx pulse one cycle", {31'h0, dbg_exc_req}, 32'h0);
        core_tx_wr = 1; step();
        core_tx_wr = 1; host_tx_rd = 1; step();
        chk("R6 tx set wins", {30'h0, tx_full, dbg_exc_req}, 32'h2);
        hwrite(32'h0);
        host_tx_rd = 1; step();
        chk("R8 tx disabled", {30'h0, tx_full, dbg_exc_req}, 32'h0);

        // trace-full flag
        trc_full_in = 1; step();
        chk("R9 trace set", host_rdata, 32'h0080_0000);
        hwrite(32'h0);
        chk("R9 R4 trace hold", host_rdata, 32'h0080_0000);

        // core reset domain
        host_we = 1; host_wdata = 32'h003C_0000; evt_in = 16'h00F0; step();
        chk("R1 before core reset", host_rdata, 32'h00BC_00F0);
        core_tx_wr = 1; step();
        core_rst_n = 0; host_we = 1; host_wdata = 32'h0; evt_in = 16'h0001; step();
        chk("R10 core reset keeps owners", host_rdata, 32'h003C_0000);
        chk("R10 core reset flags", {30'h0, tx_full, dbg_exc_req}, 32'h0);

        // power-on reset
        por_n = 0; core_rst_n = 0; host_we = 1; host_wdata = 32'hFFFF_FFFF; evt_in = 16'hFFFF;
        host_rx_wr = 1; step();
        chk("R11 por clears", host_rdata, 32'h0);
        chk("R11 por flags", {30'h0, rx_full, tx_full}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule